// File: doc/BRIEF.md
# Seven-Level Staircase Gate Pattern Generator

This block drives the 36 switch gates of a three-phase, seven-level diode-clamped inverter. It does not use space vector modulation. It keeps an electrical angle in tenths of a degree, which advances by one step on each tick. Each of the six upper switches of a leg is on while the angle lies inside that switch's own conduction window. The windows are nested around 180°, so the leg climbs from its lowest output level to its highest and back down once per turn. Each lower switch is always the inverse of its partner in the upper half.

The second and third legs use the first leg's windows with the angle displaced by a third and by two thirds of a turn. An 8-bit carrier runs freely on the clock and is compared against a duty input. While the carrier is at or above the duty value, every leg is pulled to its lowest level: all upper switches are off and all lower switches are on.

The block is used with the tick pulsing at 3600 times the wanted output frequency and with duty set to the wanted modulation depth. The gates are registered.

Top module: `mlinv_gate_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, all 36 bits of `gate_o` become 0 at that edge. Reset also returns the angle and the carrier to 0.
- R2: Leg p occupies `gate_o[p*12 +: 12]`, with p=0 for phase A, 1 for B and 2 for C. Within a leg, bit k (k=0..5) is upper switch k+1 and bit 6+k is lower switch k+1.
- R3: The upper switch of leg A is on when the angle a, in tenths of a degree, satisfies start <= a < stop. The (start, stop) windows for switches 1 to 6 are (1480,2119), (1202,2407), (1008,2587), (787,2808), (597,3003) and (319,3281).
- R4: Each lower gate is always the inverse of its matching upper gate.
- R5: Exactly six of a leg's twelve gates are on at all times. An upper switch k that is on implies that upper switch k+1 is on. Over one full turn with PWM held on, the leg A upper pattern changes exactly 12 times.
- R6: The angle counts 0 to 3599. It increments on each clock edge where `tick_i` is high, wraps from 3599 to 0, and holds when `tick_i` is low.
- R7: Leg B uses the leg A windows at angle (a+2400) mod 3600, which is 120° behind leg A. Leg C uses them at (a+1200) mod 3600.
- R8: An 8-bit carrier increments on every clock and wraps. PWM is on when carrier < `duty_i`. A `duty_i` of 255 keeps PWM on permanently, and a `duty_i` of 0 keeps it off.
- R9: While PWM is off, every upper gate is 0 and every lower gate is 1, so each leg reads 12'hFC0.
- R10: `gate_o` after an edge reflects the angle and carrier held before that edge and the `duty_i` present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Angle advance enable, one step of 0.1° |
| duty_i | input | 8 | PWM duty, compared against the carrier |
| gate_o | output | 36 | Registered gate drives, three legs of 12 |

## Verification
The assertions check the following on every cycle:
- the complement pairing of upper and lower gates;
- the nesting of the upper switches and the six-on count;
- that the angle steps, holds and wraps correctly;
- that PWM-off forces the lowest level;
- the behaviour at duty extremes.

Only the scenarios can show the following:
- that the window edges fall at the exact tenth-of-a-degree values;
- that legs B and C sit at the right offsets;
- that a full turn yields twelve pattern changes;
- that a mid-range duty removes the right fraction of on time.

// File: rtl/mlinv_pkg.sv
package mlinv_pkg;

  // Shift an angle by an offset, modulo one full turn.
  function automatic int unsigned ang_shift(input int unsigned a,
                                            input int unsigned ofs,
                                            input int unsigned turn);
    int unsigned s;
    s = a + ofs;
    if (s >= turn) s = s - turn;
    return s;
  endfunction

  // Half-open window test: start inclusive, stop exclusive.
  function automatic logic in_window(input int unsigned a,
                                     input int unsigned start,
                                     input int unsigned stop);
    return (a >= start) && (a < stop);
  endfunction

endpackage

// File: rtl/mlinv_angle_ctr.sv
module mlinv_angle_ctr #(
  parameter int TURN = 3600,
  parameter int W    = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  output logic [W-1:0] angle_o
);
  localparam logic [W-1:0] LAST = W'(TURN - 1);

  logic wrap_w;
  assign wrap_w = (angle_o == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i)       angle_o <= '0;
    else if (tick_i) angle_o <= wrap_w ? '0 : angle_o + 1'b1;
  end
endmodule

// File: rtl/mlinv_pwm_carrier.sv
module mlinv_pwm_carrier #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] duty_i,
  output logic          on_o
);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] carrier_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) carrier_q <= '0;
    else       carrier_q <= carrier_q + 1'b1;
  end

  assign on_o = (duty_i == FULL) || (carrier_q < duty_i);
endmodule

// File: rtl/mlinv_leg_window.sv
module mlinv_leg_window #(
  parameter int NDEV = 6,
  parameter int W    = 12,
  parameter logic [NDEV*W-1:0] START = '0,
  parameter logic [NDEV*W-1:0] STOP  = '0
) (
  input  logic [W-1:0]    angle_i,
  output logic [NDEV-1:0] upper_o
);
  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign upper_o[d] = mlinv_pkg::in_window(32'(angle_i),
                                             32'(START[d*W +: W]),
                                             32'(STOP[d*W +: W]));
  end
endmodule

// File: rtl/mlinv_gate_gen.sv
module mlinv_gate_gen #(
  parameter int LEVELS = 7,
  parameter int TURN   = 3600,
  parameter int ANG_W  = 12,
  parameter int CAR_W  = 8,
  parameter int PHASES = 3,
  parameter logic [(LEVELS-1)*ANG_W-1:0] WIN_START =
    {12'd319, 12'd597, 12'd787, 12'd1008, 12'd1202, 12'd1480},
  parameter logic [(LEVELS-1)*ANG_W-1:0] WIN_STOP =
    {12'd3281, 12'd3003, 12'd2808, 12'd2587, 12'd2407, 12'd2119},
  parameter logic [PHASES*ANG_W-1:0] PH_OFS = {12'd1200, 12'd2400, 12'd0}
) (
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic                             tick_i,
  input  logic [CAR_W-1:0]                 duty_i,
  output logic [PHASES*2*(LEVELS-1)-1:0]   gate_o
);
  localparam int NDEV   = LEVELS - 1;
  localparam int LEG_W  = 2 * NDEV;
  localparam int GATE_W = PHASES * LEG_W;

  logic [ANG_W-1:0]  angle_w;
  logic              pwm_on_w;
  logic [GATE_W-1:0] gate_next_w;

  mlinv_angle_ctr #(.TURN(TURN), .W(ANG_W)) u_angle (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick_i),
    .angle_o(angle_w)
  );

  mlinv_pwm_carrier #(.CW(CAR_W)) u_pwm (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .duty_i(duty_i),
    .on_o  (pwm_on_w)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    logic [ANG_W-1:0] ph_angle_w;
    logic [NDEV-1:0]  upper_w;

    assign ph_angle_w = ANG_W'(mlinv_pkg::ang_shift(32'(angle_w),
                                                    32'(PH_OFS[p*ANG_W +: ANG_W]),
                                                    32'(TURN)));

    mlinv_leg_window #(.NDEV(NDEV), .W(ANG_W),
                       .START(WIN_START), .STOP(WIN_STOP)) u_win (
      .angle_i(ph_angle_w),
      .upper_o(upper_w)
    );

    assign gate_next_w[p*LEG_W +: LEG_W] =
      pwm_on_w ? {~upper_w, upper_w} : {{NDEV{1'b1}}, {NDEV{1'b0}}};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) gate_o <= '0;
    else       gate_o <= gate_next_w;
  end
endmodule

// File: rtl/mlinv_gate_gen_chk.sv
module mlinv_gate_gen_chk #(
  parameter int NDEV   = 6,
  parameter int PHASES = 3,
  parameter int ANG_W  = 12,
  parameter int CAR_W  = 8,
  parameter int TURN   = 3600
) (
  input logic                         clk_i,
  input logic                         rst_i,
  input logic                         tick_i,
  input logic [CAR_W-1:0]             duty_i,
  input logic [ANG_W-1:0]             angle_w,
  input logic                         pwm_on_w,
  input logic [PHASES*2*NDEV-1:0]     gate_o
);
  localparam int LEG_W = 2 * NDEV;
  localparam logic [ANG_W-1:0] LAST = ANG_W'(TURN - 1);

  a_r1_reset_low: assert property (@(posedge clk_i)
    rst_i |=> (gate_o == '0));

  a_r6_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && angle_w == LAST) |=> (angle_w == '0));

  a_r6_step: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && angle_w != LAST) |=> (angle_w == ANG_W'($past(angle_w) + 1'b1)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(angle_w));

  a_r6_range: assert property (@(posedge clk_i) disable iff (rst_i)
    angle_w <= LAST);

  a_r8_full_duty: assert property (@(posedge clk_i) disable iff (rst_i)
    (duty_i == '1) |-> pwm_on_w);

  a_r8_zero_duty: assert property (@(posedge clk_i) disable iff (rst_i)
    (duty_i == '0) |-> !pwm_on_w);

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    logic [NDEV-1:0] up_w, lo_w;
    assign up_w = gate_o[p*LEG_W +: NDEV];
    assign lo_w = gate_o[p*LEG_W + NDEV +: NDEV];

    a_r4_complement: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(!rst_i) |-> (lo_w == ~up_w));

    a_r5_six_on: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(!rst_i) |-> ($countones(gate_o[p*LEG_W +: LEG_W]) == NDEV));

    a_r9_pwm_off: assert property (@(posedge clk_i) disable iff (rst_i)
      !pwm_on_w |=> (up_w == '0 && lo_w == '1));

    for (genvar d = 0; d < NDEV - 1; d++) begin : g_nest
      a_r5_nested: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!rst_i) && up_w[d]) |-> up_w[d+1]);
    end
  end
endmodule

bind mlinv_gate_gen mlinv_gate_gen_chk #(
  .NDEV(LEVELS - 1), .PHASES(PHASES), .ANG_W(ANG_W), .CAR_W(CAR_W), .TURN(TURN)
) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .tick_i  (tick_i),
  .duty_i  (duty_i),
  .angle_w (angle_w),
  .pwm_on_w(pwm_on_w),
  .gate_o  (gate_o)
);

// File: tb/mlinv_gate_gen_tb.sv
module mlinv_gate_gen_tb_top;
  localparam time CLK_P = 10ns;
  localparam int  ST[6] = '{1480, 1202, 1008, 787, 597, 319};
  localparam int  SP[6] = '{2119, 2407, 2587, 2808, 3003, 3281};
  localparam int  OFS[3] = '{0, 2400, 1200};
  localparam logic [35:0] ALL_OFF = 36'hFC0FC0FC0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  duty = 8'd255;
  logic [35:0] gate;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  mlinv_gate_gen dut_i (
    .clk_i (clk),
    .rst_i (rst),
    .tick_i(tick),
    .duty_i(duty),
    .gate_o(gate)
  );

  // Reference model built from the requirements.
  function automatic logic [5:0] up_of(int a);
    logic [5:0] r;
    for (int d = 0; d < 6; d++) r[d] = (a >= ST[d]) && (a < SP[d]);
    return r;
  endfunction

  function automatic logic [35:0] model(int ang, int car, int dty);
    logic [35:0] r;
    logic [5:0]  u;
    logic        on;
    on = (dty == 255) || (car < dty);
    for (int p = 0; p < 3; p++) begin
      u = up_of((ang + OFS[p]) % 3600);
      r[p*12 +: 12] = on ? {~u, u} : 12'hFC0;
    end
    return r;
  endfunction

  int          m_ang = 0;
  int          m_car = 0;
  logic [35:0] m_gate = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ang  <= 0;
      m_car  <= 0;
      m_gate <= '0;
    end else begin
      m_ang  <= tick ? ((m_ang == 3599) ? 0 : m_ang + 1) : m_ang;
      m_car  <= (m_car + 1) % 256;
      m_gate <= model(m_ang, m_car, int'(duty));
    end
  end

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic goto_angle(int a);
    do_reset();
    tick = 1'b1;
    repeat (a) @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    duty = 8'd255;
    repeat (3) @(negedge clk);
    chk("R1 reset clears gates", gate, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 R7 angle 0 after reset", gate,
        {6'b000011, 6'b111100, 6'b000001, 6'b111110, 6'b111111, 6'b000000});
  endtask

  task automatic t_windows();
    goto_angle(1479);
    chk("R3 a1 off before start", {30'd0, gate[5:0]}, {30'd0, 6'b111110});
    chk("R4 lower inverse", {30'd0, gate[11:6]}, {30'd0, 6'b000001});
    goto_angle(1480);
    chk("R3 a1 on at start", {30'd0, gate[5:0]}, {30'd0, 6'b111111});
    goto_angle(2118);
    chk("R3 a1 on before stop", {30'd0, gate[5:0]}, {30'd0, 6'b111111});
    goto_angle(2119);
    chk("R3 a1 off at stop", {30'd0, gate[5:0]}, {30'd0, 6'b111110});
    goto_angle(3599);
    chk("R3 all upper off at 3599", {30'd0, gate[5:0]}, '0);
  endtask

  task automatic t_wrap();
    goto_angle(3600);
    chk("R6 wrap to 0 leg A", {30'd0, gate[5:0]}, '0);
    chk("R7 leg B at wrap", {30'd0, gate[17:12]}, {30'd0, 6'b111110});
    chk("R7 leg C at wrap", {30'd0, gate[29:24]}, {30'd0, 6'b111100});
  endtask

  task automatic t_hold();
    logic [35:0] held;
    goto_angle(1479);
    held = gate;
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk("R6 hold without tick", gate, held);
    chk("R6 held angle 1479", {30'd0, gate[5:0]}, {30'd0, 6'b111110});
  endtask

  task automatic t_sweep();
    logic [5:0] prev;
    int trans = 0;
    int bad_cnt = 0;
    do_reset();
    duty = 8'd255;
    tick = 1'b1;
    prev = '0;
    for (int i = 1; i <= 3601; i++) begin
      @(negedge clk);
      chk("R3 R7 R10 sweep vs model", gate, m_gate);
      for (int p = 0; p < 3; p++)
        if ($countones(gate[p*12 +: 12]) != 6) bad_cnt++;
      if (i > 1 && gate[5:0] != prev) trans++;
      prev = gate[5:0];
    end
    tick = 1'b0;
    chk_int("R5 six gates on per leg", bad_cnt, 0);
    chk_int("R5 transitions per turn", trans, 12);
  endtask

  task automatic t_pwm_duty(int dty, int exp_off);
    int offs = 0;
    goto_angle(1800);
    @(negedge clk);
    duty = 8'(dty);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      chk("R8 R10 pwm vs model", gate, m_gate);
      if (gate[5:0] == 6'b0) begin
        offs++;
        chk("R9 off forces lowest level", gate, ALL_OFF);
      end
    end
    chk_int("R8 off cycles per carrier period", offs, exp_off);
    duty = 8'd255;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_windows();
    t_wrap();
    t_hold();
    t_sweep();
    t_pwm_duty(64, 192);
    t_pwm_duty(0, 256);
    t_pwm_duty(255, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule